// File: doc/BRIEF.md
# Two-Phase Stack Processor Core

This block is a small non-pipelined processor built around two last-in-first-out stacks. One stack holds data and the other holds return addresses. Instruction words are 9 bits wide and data words are 32 bits wide. Code and data sit in separate memories, and both are synchronous RAMs outside the core. Every instruction takes exactly two clock cycles. In the first cycle the core presents the instruction pointer and the stack top as addresses. In the second cycle it decodes the returned word, computes a result and writes it back to the stacks, the data memory or the peripheral bus.

There is no operand field. Operands are the top two data-stack entries. Each non-literal opcode carries a group number in its upper nibble, and that number alone fixes how many entries are consumed and produced. Constants come from literal words carrying 8 bits each. A run of adjacent literals builds one wide value by shifting it into the top entry. Exchanging the top two entries takes two instructions: one parks the second entry in a scratch register and a later one pushes it back.

Top module: `fsc_core`

## Requirements
- R1: While `rst` is high, the instruction pointer is cleared and the core is placed in its fetch phase. After release, the core alternates fetch and execute cycles. `imem_addr` therefore holds 0 for the first two cycles and then advances by one every two cycles while the code is all zero words.
- R2: A word with bit 8 set is a literal, and bits 7..0 are its payload. When the word before it was not a literal, the payload is pushed sign-extended to 32 bits.
- R3: When the word before it was also a literal, the top entry is replaced by (top << 8) | payload and nothing is pushed.
- R4: Every word with bit 8 clear ends a literal run, the no-op 0x00 included. The next literal then starts a new entry.
- R5: Bits 7..4 of a non-literal word select its stack effect. Groups 0 to 5 consume/produce 0/0, 0/1, 1/0, 1/1, 2/0 and 2/1 entries. The result lands on the new top and is visible to the very next instruction. DUP is 0x13, OVER is 0x14 and DROP is 0x22.
- R6: DEPTH (0x11) pushes the data-stack entry count held before it ran. RDEPTH (0x12) does the same for the return stack.
- R7: JMP (0x20) loads the pointer from the top entry. CALL (0x21) does the same and also pushes pointer+1 on the return stack. RET (0x01) pops the return stack into the pointer.
- R8: IF (0x40) consumes a target (top) and a flag (second). It branches to the target only when the flag is zero, and otherwise continues at pointer+1.
- R9: NIP (0x50) drops the second entry into a scratch register. TEMP> (0x10) pushes that register.
- R10: @ (0x30) replaces an address on top with the data-memory word at that address. ! (0x41) consumes address (top) and value (second) and writes memory in the execute cycle.
- R11: INPORT (0x31) replaces an address on top with the bus read value for that address. OUTPORT (0x42) consumes address (top) and value (second) and raises `bus_wr` for exactly one cycle.
- R12: The arithmetic opcodes take the second entry as the left operand: 0x51 add, 0x52 subtract, 0x53 and, 0x54 or, 0x55 xor, 0x56 equal, 0x57 signed greater, 0x58 signed less, 0x59 multiply (low 32 bits). Comparisons yield all ones or zero. The unary opcodes work on the top entry: 0x32 logical not (0 becomes all ones, anything else becomes 0), 0x33 shift left, 0x34 logical shift right, 0x35 arithmetic shift right.
- R13: An unlisted non-literal opcode advances the pointer by one and applies its group's stack effect. It produces 0 when the group produces an entry. Groups 6 to 15 leave the stack untouched.
- R14: Both stack counts wrap modulo 16 with no error. After 17 pushes DEPTH reports 1, and the 17th value sits on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IADDR_W | Instruction pointer presented to code memory |
| imem_data | input | 9 | Code memory word, one cycle after the address |
| dmem_raddr | output | DADDR_W | Data memory read address (top entry) |
| dmem_rdata | input | DATA_W | Data memory read word, one cycle after the address |
| dmem_waddr | output | DADDR_W | Data memory write address |
| dmem_wdata | output | DATA_W | Data memory write word |
| dmem_we | output | 1 | Data memory write enable |
| bus_addr | output | BUS_AW | Peripheral address (top entry) |
| bus_wdata | output | DATA_W | Peripheral write word |
| bus_rdata | input | DATA_W | Peripheral read word, valid in the execute cycle |
| bus_wr | output | 1 | One-cycle peripheral write strobe |

## Verification
The execute cycle of CALL does two things at once. It pops the data stack to get its target and pushes the return stack. RET pops the return stack while the data stack may still hold the caller's operands. The subroutine test probes both at once by reading RDEPTH inside the callee and adding to a value the caller left behind. A second collision is a store followed, one instruction later, by a load from the same address. It is judged by the value that reaches the bus. The literal-run logic and the stack-count update also meet in one cycle, when a chained literal must leave the count unchanged. That case is judged through constants whose upper bytes come out wrong if the count moves.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int INSTR_W = 9;
  localparam int IMM_W   = 8;

  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_RET    = 8'h01;
  localparam logic [7:0] OP_TEMP   = 8'h10;
  localparam logic [7:0] OP_DEPTH  = 8'h11;
  localparam logic [7:0] OP_RDEPTH = 8'h12;
  localparam logic [7:0] OP_DUP    = 8'h13;
  localparam logic [7:0] OP_OVER   = 8'h14;
  localparam logic [7:0] OP_JMP    = 8'h20;
  localparam logic [7:0] OP_CALL   = 8'h21;
  localparam logic [7:0] OP_DROP   = 8'h22;
  localparam logic [7:0] OP_FETCH  = 8'h30;
  localparam logic [7:0] OP_INP    = 8'h31;
  localparam logic [7:0] OP_NOT    = 8'h32;
  localparam logic [7:0] OP_SHL    = 8'h33;
  localparam logic [7:0] OP_SHR    = 8'h34;
  localparam logic [7:0] OP_SHRA   = 8'h35;
  localparam logic [7:0] OP_IF     = 8'h40;
  localparam logic [7:0] OP_STORE  = 8'h41;
  localparam logic [7:0] OP_OUTP   = 8'h42;
  localparam logic [7:0] OP_NIP    = 8'h50;
  localparam logic [7:0] OP_ADD    = 8'h51;
  localparam logic [7:0] OP_SUB    = 8'h52;
  localparam logic [7:0] OP_AND    = 8'h53;
  localparam logic [7:0] OP_OR     = 8'h54;
  localparam logic [7:0] OP_XOR    = 8'h55;
  localparam logic [7:0] OP_EQ     = 8'h56;
  localparam logic [7:0] OP_GT     = 8'h57;
  localparam logic [7:0] OP_LT     = 8'h58;
  localparam logic [7:0] OP_MUL    = 8'h59;

  typedef logic signed [2:0] step_t;

  // Net stack movement of a non-literal group (produced minus consumed).
  function automatic step_t group_step(input logic [3:0] grp);
    case (grp)
      4'd1:    return step_t'(1);
      4'd2:    return step_t'(-1);
      4'd4:    return step_t'(-2);
      4'd5:    return step_t'(-1);
      default: return step_t'(0);
    endcase
  endfunction

  // Groups that leave a result on the new top.
  function automatic logic group_push(input logic [3:0] grp);
    return (grp == 4'd1) || (grp == 4'd3) || (grp == 4'd5);
  endfunction
endpackage

// File: rtl/fsc_stack.sv
module fsc_stack import fsc_pkg::*; #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  step_t         step,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top,
  output logic [W-1:0]  second,
  output logic [AW-1:0] count
);
  localparam int N = 1 << AW;

  logic [W-1:0]  mem [N];
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_nx;

  // Count wraps naturally at 2**AW; the write lands on the new top.
  assign cnt_nx = cnt_q + AW'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (wr) mem[cnt_nx] <= wdata;
    end
  end

  assign top    = mem[cnt_q];
  assign second = mem[cnt_q - AW'(1)];
  assign count  = cnt_q;

  // A value written is what the next instruction sees on top.
  assert_fwd_top_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> top == $past(wdata));
endmodule

// File: rtl/fsc_decode.sv
module fsc_decode import fsc_pkg::*; (
  input  logic [INSTR_W-1:0] instr,
  input  logic               prev_lit,
  output logic               is_lit,
  output logic               lit_chain,
  output step_t              ds_step,
  output logic               ds_push,
  output logic               is_jmp,
  output logic               is_call,
  output logic               is_ret,
  output logic               is_if,
  output logic               is_store,
  output logic               is_out,
  output logic               is_nip
);
  logic [7:0] op;
  assign op = instr[7:0];

  always_comb begin
    is_lit    = instr[INSTR_W-1];
    lit_chain = is_lit && prev_lit;
    if (is_lit) begin
      ds_step = lit_chain ? step_t'(0) : step_t'(1);
      ds_push = 1'b1;
    end else begin
      ds_step = group_step(op[7:4]);
      ds_push = group_push(op[7:4]);
    end
  end

  assign is_jmp   = !is_lit && (op == OP_JMP);
  assign is_call  = !is_lit && (op == OP_CALL);
  assign is_ret   = !is_lit && (op == OP_RET);
  assign is_if    = !is_lit && (op == OP_IF);
  assign is_store = !is_lit && (op == OP_STORE);
  assign is_out   = !is_lit && (op == OP_OUTP);
  assign is_nip   = !is_lit && (op == OP_NIP);
endmodule

// File: rtl/fsc_alu.sv
module fsc_alu import fsc_pkg::*; #(
  parameter int W = 32
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] tos,
  input  logic [W-1:0] nos,
  output logic [W-1:0] result
);
  function automatic logic [W-1:0] alu_eval(input logic [7:0] code,
                                            input logic [W-1:0] t,
                                            input logic [W-1:0] s);
    logic [W-1:0] r;
    case (code)
      OP_ADD:  r = s + t;
      OP_SUB:  r = s - t;
      OP_AND:  r = s & t;
      OP_OR:   r = s | t;
      OP_XOR:  r = s ^ t;
      OP_EQ:   r = {W{s == t}};
      OP_GT:   r = {W{$signed(s) > $signed(t)}};
      OP_LT:   r = {W{$signed(s) < $signed(t)}};
      OP_MUL:  r = s * t;
      OP_NOT:  r = {W{t == '0}};
      OP_SHL:  r = t << 1;
      OP_SHR:  r = t >> 1;
      OP_SHRA: r = W'($signed(t) >>> 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  assign result = alu_eval(op, tos, nos);
endmodule

// File: rtl/fsc_core.sv
module fsc_core import fsc_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 11,
  parameter int DADDR_W = 10,
  parameter int BUS_AW  = 16,
  parameter int SP_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [DADDR_W-1:0] dmem_raddr,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic [DADDR_W-1:0] dmem_waddr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_wr
);
  localparam int KEEP_W = DATA_W - IMM_W;

  // Phase, pointer and scratch state
  logic               fetching_q;
  logic               exec;
  logic [IADDR_W-1:0] ip_q, ip_nx, ip_inc;
  logic [DATA_W-1:0]  temp_q;
  logic               prev_lit_q;

  // Decode outputs
  logic       d_lit, d_chain, d_push, d_jmp, d_call, d_ret, d_if, d_store, d_out, d_nip;
  step_t      d_step;
  logic [7:0] op;

  // Stack views
  logic [DATA_W-1:0]  ds_top, ds_second, ds_wdata;
  logic [SP_W-1:0]    ds_count, rs_count;
  logic [IADDR_W-1:0] rs_top, rs_second_unused_guard;
  step_t              ds_step_eff, rs_step_eff;
  logic               ds_wr, rs_wr;
  logic [DATA_W-1:0]  alu_res;

  // Named events for the assertions
  logic ev_branch_taken, ev_chain_exec;

  assign exec   = !fetching_q;
  assign op     = imem_data[7:0];
  assign ip_inc = ip_q + IADDR_W'(1);

  fsc_decode u_dec (
    .instr    (imem_data),
    .prev_lit (prev_lit_q),
    .is_lit   (d_lit),
    .lit_chain(d_chain),
    .ds_step  (d_step),
    .ds_push  (d_push),
    .is_jmp   (d_jmp),
    .is_call  (d_call),
    .is_ret   (d_ret),
    .is_if    (d_if),
    .is_store (d_store),
    .is_out   (d_out),
    .is_nip   (d_nip)
  );

  fsc_alu #(.W(DATA_W)) u_alu (
    .op    (op),
    .tos   (ds_top),
    .nos   (ds_second),
    .result(alu_res)
  );

  // Literal payload: start a new sign-extended entry or append a byte.
  function automatic logic [DATA_W-1:0] lit_merge(input logic chain,
                                                  input logic [DATA_W-1:0] top,
                                                  input logic [IMM_W-1:0] imm);
    if (chain) return {top[KEEP_W-1:0], imm};
    return {{KEEP_W{imm[IMM_W-1]}}, imm};
  endfunction

  always_comb begin
    if (d_lit) begin
      ds_wdata = lit_merge(d_chain, ds_top, imem_data[IMM_W-1:0]);
    end else begin
      case (op)
        OP_TEMP:   ds_wdata = temp_q;
        OP_DEPTH:  ds_wdata = DATA_W'(ds_count);
        OP_RDEPTH: ds_wdata = DATA_W'(rs_count);
        OP_DUP:    ds_wdata = ds_top;
        OP_OVER:   ds_wdata = ds_second;
        OP_FETCH:  ds_wdata = dmem_rdata;
        OP_INP:    ds_wdata = bus_rdata;
        OP_NIP:    ds_wdata = ds_top;
        default:   ds_wdata = alu_res;
      endcase
    end
  end

  assign ds_step_eff = exec ? d_step : step_t'(0);
  assign ds_wr       = exec && d_push;
  assign rs_step_eff = (exec && d_call) ? step_t'(1)
                     : (exec && d_ret)  ? step_t'(-1) : step_t'(0);
  assign rs_wr       = exec && d_call;

  fsc_stack #(.W(DATA_W), .AW(SP_W)) u_dstack (
    .clk   (clk),
    .rst   (rst),
    .step  (ds_step_eff),
    .wr    (ds_wr),
    .wdata (ds_wdata),
    .top   (ds_top),
    .second(ds_second),
    .count (ds_count)
  );

  fsc_stack #(.W(IADDR_W), .AW(SP_W)) u_rstack (
    .clk   (clk),
    .rst   (rst),
    .step  (rs_step_eff),
    .wr    (rs_wr),
    .wdata (ip_inc),
    .top   (rs_top),
    .second(rs_second_unused_guard),
    .count (rs_count)
  );

  // Next instruction pointer
  assign ev_branch_taken = d_if && (ds_second == '0);
  assign ev_chain_exec   = exec && d_chain;

  always_comb begin
    if (d_jmp || d_call || ev_branch_taken) ip_nx = ds_top[IADDR_W-1:0];
    else if (d_ret)                         ip_nx = rs_top;
    else                                    ip_nx = ip_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetching_q <= 1'b1;
      ip_q       <= '0;
      temp_q     <= '0;
      prev_lit_q <= 1'b0;
    end else begin
      fetching_q <= !fetching_q;
      if (exec) begin
        ip_q       <= ip_nx;
        prev_lit_q <= d_lit;
        if (d_nip) temp_q <= ds_second;
      end
    end
  end

  // Memory and bus side
  assign imem_addr  = ip_q;
  assign dmem_raddr = ds_top[DADDR_W-1:0];
  assign dmem_waddr = ds_top[DADDR_W-1:0];
  assign dmem_wdata = ds_second;
  assign dmem_we    = exec && d_store;
  assign bus_addr   = ds_top[BUS_AW-1:0];
  assign bus_wdata  = ds_second;
  assign bus_wr     = exec && d_out;

  // Assertions
  assert_phase_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    fetching_q |=> !fetching_q);
  assert_phase_exec_R1: assert property (@(posedge clk) disable iff (rst)
    !fetching_q |=> fetching_q);
  assert_ip_hold_R1: assert property (@(posedge clk) disable iff (rst)
    fetching_q |=> $stable(ip_q));
  assert_chain_keeps_depth_R3: assert property (@(posedge clk) disable iff (rst)
    ev_chain_exec |=> $stable(ds_count));
  assert_break_chain_R4: assert property (@(posedge clk) disable iff (rst)
    (exec && !d_lit) |=> !prev_lit_q);
  assert_call_push_R7: assert property (@(posedge clk) disable iff (rst)
    (exec && d_call) |=> rs_count == SP_W'($past(rs_count) + SP_W'(1)));
  assert_taken_if_R8: assert property (@(posedge clk) disable iff (rst)
    (exec && ev_branch_taken) |=> ip_q == $past(ds_top[IADDR_W-1:0]));
  assert_store_exec_R10: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !fetching_q);
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);
endmodule

// File: tb/tb_fsc_core.sv
`timescale 1ns/1ps
module tb_fsc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] imem_addr;
  logic [8:0]  imem_data;
  logic [9:0]  dmem_raddr, dmem_waddr;
  logic [31:0] dmem_rdata, dmem_wdata;
  logic        dmem_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_wr;

  always #2 clk = ~clk;

  fsc_core dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
    .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wr(bus_wr)
  );

  // Memory and peripheral models
  logic [8:0]  imem [256];
  logic [31:0] dmem [256];

  always @(posedge clk) begin
    imem_data <= imem[imem_addr[7:0]];
    if (dmem_we) dmem[dmem_waddr[7:0]] <= dmem_wdata;
    dmem_rdata <= dmem[dmem_raddr[7:0]];
  end

  function automatic logic [31:0] periph(input logic [15:0] a);
    return {a, ~a};
  endfunction
  assign bus_rdata = periph(bus_addr);

  // Bus write log, sampled mid-cycle
  logic [15:0] log_addr [512];
  logic [31:0] log_data [512];
  int log_n = 0;
  always @(negedge clk) begin
    if (!rst && bus_wr && log_n < 512) begin
      log_addr[log_n] = bus_addr;
      log_data[log_n] = bus_wdata;
      log_n = log_n + 1;
    end
  end

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int pc, base, k;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors = vectors + 1;
    if (got !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Program builder
  task automatic emit(input logic [8:0] w);
    imem[pc[7:0]] = w;
    pc = pc + 1;
  endtask
  task automatic lit(input logic [7:0] b);
    emit({1'b1, b});
  endtask
  task automatic push_small(input logic [7:0] v);
    lit(v); emit(9'h000);
  endtask
  task automatic push32(input logic [31:0] v);
    lit(v[31:24]); lit(v[23:16]); lit(v[15:8]); lit(v[7:0]); emit(9'h000);
  endtask
  task automatic outp(input logic [7:0] tag);
    push_small(tag); emit(9'h042);
  endtask
  task automatic halt();
    int h;
    emit(9'h000);
    h = pc;
    lit(8'(h)); emit(9'h020);
  endtask

  task automatic begin_prog();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 256; i++) imem[i] = 9'h000;
    pc = 0; base = log_n; k = 0;
  endtask
  task automatic run(input int cycles);
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask
  task automatic expect_out(input string req, input logic [15:0] a, input logic [31:0] d);
    chk({req, " addr"}, 32'(log_addr[base + k]), 32'(a));
    chk({req, " data"}, log_data[base + k], d);
    k = k + 1;
  endtask
  task automatic expect_count(input string req);
    chk({req, " strobe count"}, 32'(log_n - base), 32'(k));
  endtask

  function automatic logic [31:0] ref_alu(input logic [7:0] op, input logic [31:0] x,
                                          input logic [31:0] y);
    logic [63:0] p;
    case (op)
      8'h51: return x + y;
      8'h52: return x - y;
      8'h53: return x & y;
      8'h54: return x | y;
      8'h55: return x ^ y;
      8'h56: return (x == y) ? 32'hFFFF_FFFF : 32'h0;
      8'h57: return ($signed(x) > $signed(y)) ? 32'hFFFF_FFFF : 32'h0;
      8'h58: return ($signed(x) < $signed(y)) ? 32'hFFFF_FFFF : 32'h0;
      8'h59: begin p = {32'h0, x} * {32'h0, y}; return p[31:0]; end
      8'h32: return (y == 0) ? 32'hFFFF_FFFF : 32'h0;
      8'h33: return {y[30:0], 1'b0};
      8'h34: return {1'b0, y[31:1]};
      8'h35: return {y[31], y[31:1]};
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    logic [31:0] a, b, seed;
    logic [7:0]  op;
    seed = $urandom(32'h5EED_1234);

    // R1: reset state and two-cycle rhythm on an all-NOP program
    begin_prog();
    chk("R1 reset bus_wr", 32'(bus_wr), 32'h0);
    chk("R1 reset dmem_we", 32'(dmem_we), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      chk("R1 imem_addr rhythm", 32'(imem_addr), 32'(c / 2));
    end

    // R2 R3 R4: literals
    begin_prog();
    push_small(8'h80); outp(8'h10);
    lit(8'h01); lit(8'h02); lit(8'h03); emit(9'h000); outp(8'h11);
    lit(8'h07); emit(9'h000); lit(8'h09); emit(9'h051); outp(8'h12);
    lit(8'hFF); lit(8'h00); emit(9'h000); outp(8'h13);
    halt();
    run(400);
    expect_out("R2 sign-extended push", 16'h10, 32'hFFFF_FF80);
    expect_out("R3 chained literal", 16'h11, 32'h0001_0203);
    expect_out("R4 NOP separates literals", 16'h12, 32'd16);
    expect_out("R3 negative chain", 16'h13, 32'hFFFF_FF00);
    expect_count("R11");

    // R5 R6 R9 R10 R11 R13: stack effects, memory, bus, unknown opcodes
    begin_prog();
    push_small(8'd3); push_small(8'd4); emit(9'h014); outp(8'h20);
    emit(9'h013); emit(9'h051); outp(8'h21);
    emit(9'h011); outp(8'h22);
    emit(9'h022); emit(9'h011); outp(8'h23);
    push_small(8'd5); push_small(8'd6); emit(9'h050); emit(9'h010);
    outp(8'h24); outp(8'h25);
    push_small(8'd100); push_small(8'd7); emit(9'h041);
    push_small(8'd7); emit(9'h030); outp(8'h26);
    push_small(8'h33); emit(9'h031); outp(8'h27);
    push_small(8'd9); emit(9'h03F); outp(8'h28);
    emit(9'h00F); emit(9'h06A); emit(9'h011); outp(8'h29);
    emit(9'h01F); outp(8'h2A);
    halt();
    run(400);
    expect_out("R5 OVER", 16'h20, 32'd3);
    expect_out("R5 DUP then add", 16'h21, 32'd8);
    expect_out("R6 DEPTH", 16'h22, 32'd1);
    expect_out("R5 DROP empties", 16'h23, 32'd0);
    expect_out("R9 TEMP> returns parked", 16'h24, 32'd5);
    expect_out("R9 NIP keeps top", 16'h25, 32'd6);
    expect_out("R10 store then load", 16'h26, 32'd100);
    expect_out("R11 INPORT", 16'h27, periph(16'h0033));
    expect_out("R13 unknown group3 yields 0", 16'h28, 32'd0);
    expect_out("R13 groups 0 and 6 no stack effect", 16'h29, 32'd0);
    expect_out("R13 unknown group1 pushes 0", 16'h2A, 32'd0);
    expect_count("R11");
    chk("R10 memory word", dmem[7], 32'd100);

    // R6 R7 R8: call, return, conditional, jump
    begin_prog();
    push_small(8'd7); push_small(8'd60); emit(9'h021);
    outp(8'h31);
    emit(9'h012); outp(8'h32);
    push_small(8'd5); push_small(8'd80); emit(9'h040);
    push_small(8'd1); outp(8'h33);
    push_small(8'd0); push_small(8'd80); emit(9'h040);
    push_small(8'd2); outp(8'h34);
    halt();
    pc = 60;
    emit(9'h012); outp(8'h30); push_small(8'd1); emit(9'h051); emit(9'h001);
    pc = 80;
    push_small(8'd3); outp(8'h35);
    push_small(8'd95); emit(9'h020);
    push_small(8'd4); outp(8'h36);
    pc = 95;
    push_small(8'd6); outp(8'h37);
    halt();
    run(400);
    expect_out("R6 RDEPTH in callee", 16'h30, 32'd1);
    expect_out("R7 CALL/RET keeps caller data", 16'h31, 32'd8);
    expect_out("R6 RDEPTH after RET", 16'h32, 32'd0);
    expect_out("R8 nonzero flag falls through", 16'h33, 32'd1);
    expect_out("R8 zero flag branches", 16'h35, 32'd3);
    expect_out("R7 JMP", 16'h37, 32'd6);
    expect_count("R8 skipped writes");

    // R14: wrap of the data stack count
    begin_prog();
    for (int i = 1; i <= 17; i++) push_small(8'(i));
    emit(9'h011); outp(8'h50); outp(8'h51);
    halt();
    run(400);
    expect_out("R14 DEPTH wraps", 16'h50, 32'd1);
    expect_out("R14 newest on top", 16'h51, 32'd17);
    expect_count("R14");

    // R12: constrained random arithmetic
    for (int v = 0; v < 160; v++) begin
      logic [7:0] ops [13];
      ops = '{8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h58, 8'h59,
              8'h32, 8'h33, 8'h34, 8'h35};
      op = ops[$urandom % 13];
      a = $urandom; b = $urandom;
      case ($urandom % 8)
        0: b = a;
        1: a = 32'h0;
        2: a = 32'h8000_0000;
        3: b = 32'hFFFF_FFFF;
        default: ;
      endcase
      begin_prog();
      push32(a);
      if (op[7:4] == 4'h5) push32(b);
      emit({1'b0, op});
      outp(8'h60);
      halt();
      run(70);
      if (op[7:4] == 4'h5) expect_out("R12 binary op", 16'h60, ref_alu(op, a, b));
      else                 expect_out("R12 unary op", 16'h60, ref_alu(op, 32'h0, a));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule